// File: doc/BRIEF.md
# Translation Lookaside Cache with Global Entries

This block is a small, fully associative cache of finished address translations. It sits between a requester and a page-table walker. A lookup presents a 20-bit virtual page number. In the same cycle, the block reports a hit or a miss together with the cached physical frame, the attribute bits, the global flag and the page-size flag. On a miss, the caller runs the walk elsewhere and writes the result back through the fill port.

An entry maps either a 4 KB page or a 4 MB page. A 4 MB entry matches on the top ten bits of the page number only. For such an entry, the low ten bits of the returned frame come from the looked-up page number.

Any change to a mapping must be followed by one of two invalidations:
- A write to the translation base register, seen here as `flush_all`, clears every entry that is not global.
- A single-page invalidate clears only the entry that covers the given page, whether that entry is global or not.

A fill goes to the lowest-numbered free slot. When every slot is in use, a round-robin pointer picks the victim.

Top module: `tlb_cache`

## Requirements
- R1: After reset every slot is empty, so every lookup reports a miss.
- R2: A 4 KB entry hits only when all 20 page-number bits equal its tag. A hit returns the stored frame, attribute bits, global flag and size flag (`lk_large`=0) combinationally, in the same cycle as `lk_vpn`.
- R3: A 4 MB entry (`fill_large`=1) hits whenever `lk_vpn[19:10]` equals its tag bits [19:10]. The returned frame is {stored frame[19:10], `lk_vpn[9:0]`}, with `lk_large`=1.
- R4: A cycle with `flush_all`=1 empties every slot whose global flag (`fill_global` at fill time) is 0 and keeps every slot whose global flag is 1.
- R5: A cycle with `inval_en`=1 empties only the slot covering `inval_vpn`, including a global slot and a 4 MB slot matched on bits [19:10]. All other slots are unchanged.
- R6: When no cached entry overlaps the filled page, a fill is written into the lowest-indexed empty slot, and the round-robin pointer does not move.
- R7: When all slots are full and nothing overlaps, a fill replaces the slot named by the round-robin pointer. The pointer starts at 0, advances by one after each such replacement, and wraps after the last slot.
- R8: A fill presented in the same cycle as `flush_all` or `inval_en` is dropped.
- R9: A fill whose page overlaps cached entries empties all of them and is written into the lowest-indexed overlapping slot. A later lookup returns the new frame.
- R10: At most one slot matches any lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_hit | output | 1 | A slot matches `lk_vpn` |
| lk_pfn | output | 20 | Translated frame number |
| lk_attr | output | 6 | Attribute bits of the matching slot |
| lk_global | output | 1 | Global flag of the matching slot |
| lk_large | output | 1 | The matching slot maps a 4 MB page |
| fill_en | input | 1 | Write a walker result |
| fill_vpn | input | 20 | Page number of the fill |
| fill_pfn | input | 20 | Frame number of the fill |
| fill_attr | input | 6 | Attribute bits of the fill |
| fill_global | input | 1 | Fill is global |
| fill_large | input | 1 | Fill maps a 4 MB page |
| flush_all | input | 1 | Base-register write: clear non-global slots |
| inval_en | input | 1 | Single-page invalidate |
| inval_vpn | input | 20 | Page number to invalidate |

## Verification
The bench targets four kinds of error, and each one shows up at the lookup port:
- A flush that ignores the global flag makes the global 4 KB and 4 MB pages miss afterwards.
- A single-page invalidate that compares all 20 bits against a 4 MB entry leaves that entry hitting.
- A victim choice that skips the free-slot search, or moves the round-robin pointer on a free-slot fill, evicts the wrong page in the later eviction sequence.
- A fill that wins over a simultaneous flush leaves a page that should be absent. A refill that duplicates rather than overwrites returns the stale frame, or two slots matching at once.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VPN_W   = 20;
  localparam int PFN_W   = 20;
  localparam int SUPER_W = 10;
  localparam int ATTR_W  = 6;
  localparam int HI_W    = VPN_W - SUPER_W;

  typedef struct packed {
    logic              glb;
    logic              big;
    logic [VPN_W-1:0]  tag;
    logic [PFN_W-1:0]  pfn;
    logic [ATTR_W-1:0] attr;
  } tlb_ent_t;

  // True when a slot holding (tag, big) translates page va.
  function automatic logic covers(input logic [VPN_W-1:0] tag, input logic big,
                                  input logic [VPN_W-1:0] va);
    logic hi_eq, lo_eq;
    hi_eq = (tag[VPN_W-1:SUPER_W] == va[VPN_W-1:SUPER_W]);
    lo_eq = (tag[SUPER_W-1:0] == va[SUPER_W-1:0]);
    return hi_eq && (big || lo_eq);
  endfunction

  // True when two mappings share any page.
  function automatic logic overlaps(input logic [VPN_W-1:0] tag_a, input logic big_a,
                                    input logic [VPN_W-1:0] tag_b, input logic big_b);
    logic hi_eq, lo_eq;
    hi_eq = (tag_a[VPN_W-1:SUPER_W] == tag_b[VPN_W-1:SUPER_W]);
    lo_eq = (tag_a[SUPER_W-1:0] == tag_b[SUPER_W-1:0]);
    return hi_eq && (big_a || big_b || lo_eq);
  endfunction
endpackage

// File: rtl/tlb_slot.sv
module tlb_slot
  import tlb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             flush_all,
  input  logic             inval_en,
  input  logic [VPN_W-1:0] inval_vpn,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic             fill_large,
  input  logic             fill_go,
  input  logic             wr_sel,
  input  tlb_ent_t         wr_ent,
  output logic             vld,
  output logic             lk_match,
  output logic             ovl_match,
  output tlb_ent_t         ent
);
  logic     vld_q, vld_d;
  tlb_ent_t ent_q, ent_d;
  logic     inv_match, ent_en;

  always_comb begin
    lk_match  = vld_q && covers(ent_q.tag, ent_q.big, lk_vpn);
    inv_match = vld_q && covers(ent_q.tag, ent_q.big, inval_vpn);
    ovl_match = vld_q && overlaps(ent_q.tag, ent_q.big, fill_vpn, fill_large);
  end

  always_comb begin
    vld_d  = vld_q;
    ent_d  = ent_q;
    ent_en = 1'b0;
    if (wr_sel) begin
      vld_d  = 1'b1;
      ent_d  = wr_ent;
      ent_en = 1'b1;
    end else if (inval_en && inv_match) begin
      vld_d = 1'b0;
    end else if (flush_all && !ent_q.glb) begin
      vld_d = 1'b0;
    end else if (fill_go && ovl_match) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (ent_en) ent_q <= ent_d;
  end

  assign vld = vld_q;
  assign ent = ent_q;

  a_r4_flush_keeps_global: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && vld_q && ent_q.glb && !(inval_en && inv_match)) |=> vld_q);
  a_r4_flush_drops_local: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && !ent_q.glb) |=> !vld_q);
  a_r5_inval_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (inval_en && inv_match) |=> !vld_q);
  a_r8_no_fill_on_flush: assert property (@(posedge clk) disable iff (!rst_n)
    ((flush_all || inval_en) && !vld_q) |=> !vld_q);
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int NUM_ENTRIES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fill_go,
  input  logic [NUM_ENTRIES-1:0] vld_vec,
  input  logic [NUM_ENTRIES-1:0] ovl_vec,
  output logic [NUM_ENTRIES-1:0] wr_vec
);
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENTRIES - 1);

  logic [IDX_W-1:0]       ptr_q, ptr_d;
  logic [NUM_ENTRIES-1:0] free_vec, first_free, first_ovl, rr_vec;
  logic                   any_free, any_ovl, use_rr;

  assign free_vec = ~vld_vec;
  assign any_free = |free_vec;
  assign any_ovl  = |ovl_vec;

  // Lowest-index select on the free and overlap vectors.
  generate
    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_pri
      if (i == 0) begin : g_first
        assign first_free[i] = free_vec[i];
        assign first_ovl[i]  = ovl_vec[i];
      end else begin : g_rest
        assign first_free[i] = free_vec[i] && !(|free_vec[i-1:0]);
        assign first_ovl[i]  = ovl_vec[i]  && !(|ovl_vec[i-1:0]);
      end
      assign rr_vec[i] = (ptr_q == IDX_W'(i));
    end
  endgenerate

  always_comb begin
    use_rr = 1'b0;
    wr_vec = '0;
    if (fill_go) begin
      if (any_ovl)       wr_vec = first_ovl;
      else if (any_free) wr_vec = first_free;
      else begin
        wr_vec = rr_vec;
        use_rr = 1'b1;
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (use_rr) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  a_r7_ptr_moves_on_evict_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_go && !any_ovl && !any_free) |=> $stable(ptr_q));
  a_r6_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec));
  a_r6_free_first: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_go && !any_ovl && any_free) |-> ((wr_vec & vld_vec) == '0));
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_ENTRIES-1:0] hit_vec,
  input  tlb_ent_t               ents [NUM_ENTRIES],
  output logic                   hit,
  output tlb_ent_t               sel
);
  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (hit_vec[i]) sel = sel | ents[i];
    end
    hit = |hit_vec;
  end

  a_r10_onehot_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/tlb_cache.sv
module tlb_cache
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [ATTR_W-1:0] lk_attr,
  output logic              lk_global,
  output logic              lk_large,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [ATTR_W-1:0] fill_attr,
  input  logic              fill_global,
  input  logic              fill_large,
  input  logic              flush_all,
  input  logic              inval_en,
  input  logic [VPN_W-1:0]  inval_vpn
);
  logic [NUM_ENTRIES-1:0] vld_vec, hit_vec, ovl_vec, wr_vec;
  tlb_ent_t               ents [NUM_ENTRIES];
  tlb_ent_t               wr_ent, sel;
  logic                   fill_go;

  // Invalidation of either kind wins over a fill in the same cycle.
  assign fill_go = fill_en && !flush_all && !inval_en;

  always_comb begin
    wr_ent.glb  = fill_global;
    wr_ent.big  = fill_large;
    wr_ent.tag  = fill_vpn;
    wr_ent.pfn  = fill_pfn;
    wr_ent.attr = fill_attr;
  end

  generate
    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
      tlb_slot u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_vpn    (lk_vpn),
        .flush_all (flush_all),
        .inval_en  (inval_en),
        .inval_vpn (inval_vpn),
        .fill_vpn  (fill_vpn),
        .fill_large(fill_large),
        .fill_go   (fill_go),
        .wr_sel    (wr_vec[i]),
        .wr_ent    (wr_ent),
        .vld       (vld_vec[i]),
        .lk_match  (hit_vec[i]),
        .ovl_match (ovl_vec[i]),
        .ent       (ents[i])
      );
    end
  endgenerate

  tlb_victim #(.NUM_ENTRIES(NUM_ENTRIES)) u_victim (
    .clk     (clk),
    .rst_n   (rst_n),
    .fill_go (fill_go),
    .vld_vec (vld_vec),
    .ovl_vec (ovl_vec),
    .wr_vec  (wr_vec)
  );

  tlb_lookup #(.NUM_ENTRIES(NUM_ENTRIES)) u_lookup (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_vec (hit_vec),
    .ents    (ents),
    .hit     (lk_hit),
    .sel     (sel)
  );

  always_comb begin
    lk_attr   = sel.attr;
    lk_global = sel.glb;
    lk_large  = sel.big;
    lk_pfn    = sel.big ? {sel.pfn[PFN_W-1:SUPER_W], lk_vpn[SUPER_W-1:0]} : sel.pfn;
  end

  a_r8_fill_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all || inval_en) |-> (wr_vec == '0));
  a_r1_reset_empty: assert property (@(posedge clk)
    $rose(rst_n) |-> (vld_vec == '0));
endmodule

// File: tb/tlb_cache_test.sv
`timescale 1ns/1ps
module tlb_cache_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] lk_vpn;
  logic        lk_hit;
  logic [19:0] lk_pfn;
  logic [5:0]  lk_attr;
  logic        lk_global, lk_large;
  logic        fill_en;
  logic [19:0] fill_vpn, fill_pfn;
  logic [5:0]  fill_attr;
  logic        fill_global, fill_large;
  logic        flush_all, inval_en;
  logic [19:0] inval_vpn;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  tlb_cache uut (
    .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_pfn(lk_pfn),
    .lk_attr(lk_attr), .lk_global(lk_global), .lk_large(lk_large),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_attr(fill_attr), .fill_global(fill_global), .fill_large(fill_large),
    .flush_all(flush_all), .inval_en(inval_en), .inval_vpn(inval_vpn)
  );

  // {op, vpn, pfn, attr, glb, large, exp_hit, exp_pfn, exp_attr, req}
  // op: 0 fill, 1 lookup, 2 flush, 3 single-page invalidate
  localparam int NV = 16;
  localparam logic [80:0] VEC [NV] = '{
    {2'd1, 20'h00010, 20'h00000, 6'h00, 1'b0, 1'b0, 1'b0, 20'h00000, 6'h00, 4'd1},  // R1
    {2'd0, 20'h00010, 20'h0ABCD, 6'h03, 1'b0, 1'b0, 1'b0, 20'h00000, 6'h00, 4'd2},
    {2'd1, 20'h00010, 20'h00000, 6'h00, 1'b0, 1'b0, 1'b1, 20'h0ABCD, 6'h03, 4'd2},  // R2
    {2'd0, 20'h00400, 20'h12300, 6'h05, 1'b1, 1'b1, 1'b0, 20'h00000, 6'h00, 4'd3},
    {2'd1, 20'h00555, 20'h00000, 6'h00, 1'b0, 1'b0, 1'b1, 20'h12155, 6'h05, 4'd3},  // R3
    {2'd1, 20'h00011, 20'h00000, 6'h00, 1'b0, 1'b0, 1'b0, 20'h00000, 6'h00, 4'd2},  // R2
    {2'd0, 20'h00020, 20'h00777, 6'h01, 1'b1, 1'b0, 1'b0, 20'h00000, 6'h00, 4'd4},
    {2'd2, 20'h00000, 20'h00000, 6'h00, 1'b0, 1'b0, 1'b0, 20'h00000, 6'h00, 4'd4},
    {2'd1, 20'h00010, 20'h00000, 6'h00, 1'b0, 1'b0, 1'b0, 20'h00000, 6'h00, 4'd4},  // R4
    {2'd1, 20'h00020, 20'h00000, 6'h00, 1'b0, 1'b0, 1'b1, 20'h00777, 6'h01, 4'd4},  // R4
    {2'd1, 20'h007FF, 20'h00000, 6'h00, 1'b0, 1'b0, 1'b1, 20'h123FF, 6'h05, 4'd4},  // R4
    {2'd3, 20'h00020, 20'h00000, 6'h00, 1'b0, 1'b0, 1'b0, 20'h00000, 6'h00, 4'd5},
    {2'd1, 20'h00020, 20'h00000, 6'h00, 1'b0, 1'b0, 1'b0, 20'h00000, 6'h00, 4'd5},  // R5
    {2'd1, 20'h00400, 20'h00000, 6'h00, 1'b0, 1'b0, 1'b1, 20'h12000, 6'h05, 4'd5},  // R5
    {2'd3, 20'h007AB, 20'h00000, 6'h00, 1'b0, 1'b0, 1'b0, 20'h00000, 6'h00, 4'd5},
    {2'd1, 20'h00400, 20'h00000, 6'h00, 1'b0, 1'b0, 1'b0, 20'h00000, 6'h00, 4'd5}   // R5
  };

  task automatic idle();
    fill_en = 0; fill_vpn = '0; fill_pfn = '0; fill_attr = '0;
    fill_global = 0; fill_large = 0; flush_all = 0; inval_en = 0; inval_vpn = '0;
  endtask

  task automatic do_fill(input logic [19:0] v, input logic [19:0] p, input logic [5:0] a,
                         input logic g, input logic lg, input logic fl);
    @(negedge clk);
    fill_en = 1; fill_vpn = v; fill_pfn = p; fill_attr = a;
    fill_global = g; fill_large = lg; flush_all = fl;
    @(negedge clk);
    idle();
  endtask

  task automatic do_inval(input logic [19:0] v);
    @(negedge clk);
    inval_en = 1; inval_vpn = v;
    @(negedge clk);
    idle();
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush_all = 1;
    @(negedge clk);
    idle();
  endtask

  task automatic chk(input logic [19:0] v, input logic eh, input logic [19:0] ep,
                     input logic [5:0] ea, input string req);
    @(negedge clk);
    lk_vpn = v;
    #1;
    n_chk++;
    if (lk_hit !== eh || (eh && (lk_pfn !== ep || lk_attr !== ea))) begin
      n_bad++;
      $display("FAIL %s vpn=%h actual hit=%b pfn=%h attr=%h expected hit=%b pfn=%h attr=%h",
               req, v, lk_hit, lk_pfn, lk_attr, eh, ep, ea);
    end
  endtask

  task automatic chk_flags(input logic [19:0] v, input logic eg, input logic el, input string req);
    @(negedge clk);
    lk_vpn = v;
    #1;
    n_chk++;
    if (lk_hit !== 1'b1 || lk_global !== eg || lk_large !== el) begin
      n_bad++;
      $display("FAIL %s vpn=%h actual hit=%b glb=%b large=%b expected hit=1 glb=%b large=%b",
               req, v, lk_hit, lk_global, lk_large, eg, el);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    idle();
    lk_vpn = '0;
    rst_n  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [80:0] r;
      r = VEC[i];
      case (r[80:79])
        2'd0: do_fill(r[78:59], r[58:39], r[38:33], r[32], r[31], 1'b0);
        2'd1: chk(r[78:59], r[30], r[29:10], r[9:4], $sformatf("R%0d", r[3:0]));
        2'd2: do_flush();
        default: do_inval(r[78:59]);
      endcase
    end

    // R2 / R3: flags returned with the hit
    do_fill(20'h00800, 20'h55000, 6'h02, 1'b1, 1'b1, 1'b0);
    chk_flags(20'h00A01, 1'b1, 1'b1, "R3");
    do_inval(20'h00800);
    do_fill(20'h00030, 20'h00333, 6'h04, 1'b0, 1'b0, 1'b0);
    chk_flags(20'h00030, 1'b0, 1'b0, "R2");
    do_inval(20'h00030);

    // R6 / R7: fill eight free slots, then evict in round-robin order
    for (int k = 0; k < 8; k++)
      do_fill(20'h00100 + 20'(k), (20'h00100 + 20'(k)) ^ 20'hF0000, 6'h00, 1'b0, 1'b0, 1'b0);
    chk(20'h00107, 1'b1, 20'hF0107, 6'h00, "R6");
    do_fill(20'h00108, 20'hF0108, 6'h00, 1'b0, 1'b0, 1'b0);  // evicts slot 0
    chk(20'h00100, 1'b0, 20'h0, 6'h00, "R7");
    chk(20'h00108, 1'b1, 20'hF0108, 6'h00, "R7");
    do_fill(20'h00109, 20'hF0109, 6'h00, 1'b0, 1'b0, 1'b0);  // evicts slot 1
    chk(20'h00101, 1'b0, 20'h0, 6'h00, "R7");
    do_inval(20'h00103);                                     // frees slot 3
    do_fill(20'h0010A, 20'hF010A, 6'h00, 1'b0, 1'b0, 1'b0);  // lands in slot 3
    chk(20'h00102, 1'b1, 20'hF0102, 6'h00, "R6");
    do_fill(20'h0010B, 20'hF010B, 6'h00, 1'b0, 1'b0, 1'b0);  // evicts slot 2
    chk(20'h00102, 1'b0, 20'h0, 6'h00, "R7");
    chk(20'h0010A, 1'b1, 20'hF010A, 6'h00, "R6");
    do_fill(20'h0010C, 20'hF010C, 6'h00, 1'b0, 1'b0, 1'b0);  // evicts slot 3
    chk(20'h0010A, 1'b0, 20'h0, 6'h00, "R7");

    // R9: refill of a cached page overwrites it
    do_fill(20'h00104, 20'h0BEEF, 6'h3F, 1'b0, 1'b0, 1'b0);
    chk(20'h00104, 1'b1, 20'h0BEEF, 6'h3F, "R9");
    chk(20'h00105, 1'b1, 20'hF0105, 6'h00, "R9");
    // R9: a 4 MB fill clears every 4 KB slot it covers
    do_fill(20'h00100, 20'h40000, 6'h11, 1'b0, 1'b1, 1'b0);
    chk(20'h00105, 1'b1, 20'h40105, 6'h11, "R9");

    // R8: fill together with flush is dropped
    do_fill(20'h00200, 20'h00222, 6'h00, 1'b1, 1'b0, 1'b1);
    chk(20'h00200, 1'b0, 20'h0, 6'h00, "R8");
    // R8: fill together with invalidate is dropped
    @(negedge clk);
    fill_en = 1; fill_vpn = 20'h00300; fill_pfn = 20'h00333; inval_en = 1; inval_vpn = 20'h00999;
    @(negedge clk);
    idle();
    chk(20'h00300, 1'b0, 20'h0, 6'h00, "R8");

    // R1: reset in mid-run empties the cache
    do_fill(20'h00500, 20'h00555, 6'h00, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk(20'h00500, 1'b0, 20'h0, 6'h00, "R1");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule